// File: doc/BRIEF.md
# Table-Driven PWM Sequence Player

This block plays a fixed pattern of PWM levels that software or a neighbouring block has loaded into a five-slot on-chip table. Each slot packs two fields. One is a dwell, measured in whole PWM periods. The other is a duty amplitude. After a start pulse, the player steps through the slots from the lowest index to the highest. For each slot it emits exactly the requested number of 256-clock periods at that slot's duty. It then moves on without losing a clock.

Loading the table uses a valid/ready port. `wr_ready_o` is high only while the player is idle. A slot is written on any clock in which `wr_valid_i` and `wr_ready_o` are both high. While a sequence is playing, ready is low. A writer holding valid must keep address and data stable until ready returns. A transfer whose address is not below five is consumed and discarded. Control (`start_i`) and status (`busy_o`, `done_o`) are plain level and pulse pins.

Top module: `pwm_seq_player`

## Requirements
- R1: After reset, `busy_o`, `pwm_o` and `done_o` are low, `wr_ready_o` is high, and every table slot holds zero.
- R2: A start sampled while idle raises `busy_o` on the next clock, and that clock is count 0 of the first period. Within a period of 256 clocks, `pwm_o` is high for count c exactly when c is below the slot's duty.
- R3: The duty of a slot equals its 8-bit amplitude, except that amplitude 255 means full on (duty 256). Amplitude 0 keeps the output low for the whole period, and 255 keeps it high for the whole period. The high time never exceeds one period.
- R4: A slot word is 14 bits: bits 13:8 are the period count and bits 7:0 are the amplitude. Slots play in ascending index order 0 to 4, each for exactly its period count. `busy_o` stays high for 256 times the sum of the counts.
- R5: A slot with period count zero is skipped and takes no clocks. If every count is zero, `done_o` pulses on the clock after the start and `busy_o` never rises.
- R6: The duty in use changes only at a period boundary, when the count returns to 0. The next slot's first period follows the previous period with no gap clock.
- R7: On the clock after the final period's last clock, `busy_o` and `pwm_o` are low and `done_o` is high for exactly one clock. The output stays low while idle.
- R8: A start pulse arriving while busy is ignored. The sequence in progress continues unchanged.
- R9: `wr_ready_o` equals not-busy. A write is taken when valid and ready are both high and the address is 0 to 4. Addresses 5 to 7 are dropped. Writes offered while busy do not alter the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; acted on only while idle |
| wr_valid_i | input | 1 | Table write request valid |
| wr_ready_o | output | 1 | Table write port ready (idle) |
| wr_addr_i | input | 3 | Table slot index |
| wr_data_i | input | 14 | Slot word: {count[5:0], amplitude[7:0]} |
| pwm_o | output | 1 | PWM output |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse at sequence end |

## Verification
A directed table mixes a zero-amplitude slot, a full-on slot, a skipped slot and mid-range amplitudes. This distinguishes the two duty extremes from ordinary compares and shows that skipping costs no clocks. An all-zero-count table isolates the immediate-done path. A single slot at the maximum count exercises the widest repeat counter. Seeded random tables, biased toward amplitudes 0 and 255 and toward zero counts, are compared clock by clock against a bench model. During one playback a start pulse and a table write are offered while busy, and out-of-range write addresses are used, so that ignored inputs show up as waveform differences in later playbacks.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  localparam int CNT_W   = 8;
  localparam int REP_W   = 6;
  localparam int AMP_W   = 8;
  localparam int ENTRY_W = REP_W + AMP_W;
  localparam int DUTY_W  = CNT_W + 1;
  localparam int PERIOD  = 1 << CNT_W;

  typedef struct packed {
    logic [REP_W-1:0] rep;
    logic [AMP_W-1:0] amp;
  } slot_t;

  // Amplitude code all-ones selects full on; other codes map directly, clamped to one period.
  function automatic logic [DUTY_W-1:0] amp_to_duty(input logic [AMP_W-1:0] amp);
    logic [DUTY_W-1:0] d;
    if (amp == {AMP_W{1'b1}}) d = DUTY_W'(PERIOD);
    else                      d = DUTY_W'(amp);
    if (d > DUTY_W'(PERIOD))  d = DUTY_W'(PERIOD);
    return d;
  endfunction
endpackage

// File: rtl/pwm_seq_table.sv
module pwm_seq_table
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busy_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  slot_t                 wr_slot_i,
  output slot_t [DEPTH-1:0]     slots_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                      slots_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    slots_o[g] <= wr_slot_i;
    end
  end

  AST_WR_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> !busy_i); // R9

endmodule

// File: rtl/pwm_seq_scan.sv
module pwm_seq_scan
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  slot_t [DEPTH-1:0]  slots_i,
  input  logic  [IDX_W:0]    from_i,
  output logic               hit_o,
  output logic  [IDX_W-1:0]  idx_o
);

  logic [DEPTH-1:0] eligible;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign eligible[g] = (slots_i[g].rep != '0) && ((IDX_W+1)'(g) >= from_i);
  end

  // Lowest eligible index wins.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pwm_seq_period.sv
module pwm_seq_period
  import pwm_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [DUTY_W-1:0]  duty_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o,
  output logic               pwm_o
);

  logic [DUTY_W-1:0] duty_eff;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_o <= '0;
    else               cnt_o <= cnt_o + 1'b1;
  end

  assign duty_eff = (duty_i > DUTY_W'(PERIOD)) ? DUTY_W'(PERIOD) : duty_i;
  assign wrap_o   = run_i && (cnt_o == {CNT_W{1'b1}});
  assign pwm_o    = run_i && ({1'b0, cnt_o} < duty_eff);

  AST_CNT_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> cnt_o == '0); // R2

endmodule

// File: rtl/pwm_seq_player.sv
module pwm_seq_player
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                wr_valid_i,
  output logic                wr_ready_o,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [ENTRY_W-1:0]  wr_data_i,
  output logic                pwm_o,
  output logic                busy_o,
  output logic                done_o
);

  logic              busy_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [REP_W-1:0]  rem_q;
  logic [DUTY_W-1:0] duty_q;

  slot_t [DEPTH-1:0] slots;
  logic              wr_en;
  logic [IDX_W:0]    scan_from;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              start_ok;
  slot_t             next_slot;

  assign wr_ready_o = !busy_q;
  assign wr_en      = wr_valid_i && wr_ready_o && ({1'b0, wr_addr_i} < (IDX_W+1)'(DEPTH));
  assign start_ok   = start_i && !busy_q;
  assign scan_from  = busy_q ? ({1'b0, idx_q} + 1'b1) : '0;
  assign next_slot  = slots[hit_idx];

  pwm_seq_table #(.DEPTH(DEPTH)) u_table (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy_q),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_addr_i),
    .wr_slot_i (slot_t'(wr_data_i)),
    .slots_o   (slots)
  );

  pwm_seq_scan #(.DEPTH(DEPTH)) u_scan (
    .slots_i (slots),
    .from_i  (scan_from),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  pwm_seq_period u_period (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy_q),
    .duty_i (duty_q),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .pwm_o  (pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
      duty_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok || (busy_q && wrap && rem_q == REP_W'(1))) begin
        if (hit) begin
          busy_q <= 1'b1;
          idx_q  <= hit_idx;
          rem_q  <= next_slot.rep;
          duty_q <= amp_to_duty(next_slot.amp);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          duty_q <= '0;
        end
      end else if (busy_q && wrap) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !pwm_o); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_o); // R7
  AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$past(wrap)) |-> $stable(duty_q)); // R6
  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> rem_q != '0); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !wrap) |=> (busy_q && $stable(idx_q))); // R8
  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && $past(wrap)) |-> cnt == '0); // R6

endmodule

// File: tb/pwm_seq_player_tb.sv
module pwm_seq_player_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, wr_valid_i;
  logic        wr_ready_o;
  logic [2:0]  wr_addr_i;
  logic [13:0] wr_data_i;
  logic        pwm_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [13:0] shadow [5];

  always #2 clk = ~clk;  // 250 MHz

  pwm_seq_player u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_valid_i(wr_valid_i),
    .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int duty_of(input logic [7:0] amp);
    return (amp == 8'hFF) ? 256 : int'(amp);
  endfunction

  function automatic int total_clocks();
    int t = 0;
    for (int i = 0; i < 5; i++) t += 256 * int'(shadow[i][13:8]);
    return t;
  endfunction

  function automatic bit exp_out(input int k);
    int rest = k;
    for (int i = 0; i < 5; i++) begin
      int len = 256 * int'(shadow[i][13:8]);
      if (rest < len) return ((rest % 256) < duty_of(shadow[i][7:0]));
      rest -= len;
    end
    return 1'b0;
  endfunction

  task automatic wr(input int a, input logic [13:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_addr_i  = a[2:0];
    wr_data_i  = d;
    check(wr_ready_o == 1'b1, "R9 ready while idle", int'(wr_ready_o), 1);
    @(negedge clk);
    wr_valid_i = 1'b0;
    if (a < 5) shadow[a] = d;
  endtask

  task automatic play(input bit inject);
    int total = total_clocks();
    int mid   = total / 2;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (total == 0) begin
      check(done_o && !busy_o, "R5 all-zero immediate done", int'({busy_o, done_o}), 1);
      @(negedge clk);
      check(!done_o && !busy_o, "R5 done single, never busy", int'({busy_o, done_o}), 0);
      return;
    end
    for (int k = 0; k < total; k++) begin
      bit e = exp_out(k);
      // R2 R3 R4 R6: per-clock waveform against the model
      check(busy_o && !done_o && (pwm_o == e), "R2/R4 waveform",
            int'({busy_o, done_o, pwm_o}), int'({1'b1, 1'b0, e}));
      if (inject && k == mid) begin
        start_i    = 1'b1;   // R8: must be ignored
        wr_valid_i = 1'b1;   // R9: must not be taken
        wr_addr_i  = 3'd0;
        wr_data_i  = 14'h3FFF;
        check(wr_ready_o == 1'b0, "R9 not ready while busy", int'(wr_ready_o), 0);
      end else begin
        start_i    = 1'b0;
        wr_valid_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i    = 1'b0;
    wr_valid_i = 1'b0;
    check(!busy_o && done_o && !pwm_o, "R7 end of sequence",
          int'({busy_o, done_o, pwm_o}), 3'b010);
    @(negedge clk);
    check(!busy_o && !done_o && !pwm_o, "R7 done is one clock",
          int'({busy_o, done_o, pwm_o}), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst = 1'b1; start_i = 1'b0; wr_valid_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    for (int i = 0; i < 5; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !pwm_o && !done_o && wr_ready_o, "R1 reset state",
          int'({busy_o, pwm_o, done_o, wr_ready_o}), 1);

    // R1 R5: table is empty after reset, so a start finishes at once
    play(1'b0);

    // Directed: zero amp, full on, skipped slot, mid amps (R3 R4 R5 R6)
    wr(0, {6'd1, 8'd0});
    wr(1, {6'd2, 8'd255});
    wr(2, {6'd0, 8'd77});
    wr(3, {6'd1, 8'd128});
    wr(4, {6'd2, 8'd1});
    play(1'b1);   // R8 R9 injection mid-run
    play(1'b0);   // table must be unchanged by the busy write (R9)

    // R9: out-of-range addresses dropped
    wr(5, {6'd7, 8'd9});
    wr(7, {6'd5, 8'd3});
    play(1'b0);

    // R4: widest count on one slot
    for (int i = 0; i < 5; i++) wr(i, 14'd0);
    wr(2, {6'd63, 8'd200});
    play(1'b0);

    // R3: only extremes, adjacent slots
    wr(2, {6'd0, 8'd0});
    wr(0, {6'd1, 8'd255});
    wr(4, {6'd1, 8'd254});
    wr(1, {6'd1, 8'd0});
    play(1'b0);

    // Random tables
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 5; i++) begin
        int sel = $urandom % 4;
        logic [7:0] a = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd255 : 8'($urandom);
        wr(i, {6'($urandom % 4), a});
      end
      play(r[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule